// File: doc/BRIEF.md
# Settable Seconds Countdown Timer

This block is a key-driven countdown timer with a two-digit seconds readout. It has a setting mode and a counting mode. In setting mode the up and down keys change a start value. The enter key copies that value into the counter and starts it. In counting mode the counter loses one every second. When the counter reaches zero the block enters an expired state. In that state the readout shows "00" and flashes at 1 Hz until the set key is pressed.

The four keys arrive as clean pulses, each one clock wide. Debouncing has already been done upstream. The block drives two BCD digits and a blank line to a display multiplexer that lies outside the block. A prescaler divides the system clock down to the one-second tick. `CLK_HZ` sets the clock frequency and `MAX_SECS` sets the largest start value.

Top module: `countdown_secs`

## Requirements
- R1: After reset the block is in setting mode with start value 1, so the readout shows tens=0, ones=1, and blank is 0.
- R2: In setting mode each up pulse raises the start value by 1. From `MAX_SECS` (59) it wraps to 1.
- R3: In setting mode each down pulse lowers the start value by 1. From 1 it wraps to `MAX_SECS`.
- R4: Key priority in setting mode is enter, then up, then down. A set pulse in setting mode changes nothing.
- R5: An enter pulse in setting mode clears the prescaler and loads the counter with the start value. The readout then shows each value for exactly `CLK_HZ` cycles before it drops by one.
- R6: In counting mode and in the expired state, the up, down and enter pulses are ignored. The readout and the timing of the one-second steps stay unchanged.
- R7: A set pulse in counting mode or in the expired state returns the block to setting mode. The readout then shows the kept start value with blank 0.
- R8: On reaching zero the readout shows 00. Blank is 0 for the first `CLK_HZ/2` cycles of each second and 1 for the other half, and this repeats until set is pressed.
- R9: The tens output carries value/10 and the ones output carries value mod 10, each as a 4-bit BCD digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| keySet | input | 1 | One-cycle pulse: stop counting and enter setting mode |
| keyUp | input | 1 | One-cycle pulse: raise the start value |
| keyDown | input | 1 | One-cycle pulse: lower the start value |
| keyEnter | input | 1 | One-cycle pulse: start the countdown |
| tensBcd | output | 4 | BCD tens digit of the readout |
| onesBcd | output | 4 | BCD ones digit of the readout |
| blankDisp | output | 1 | Turns the readout off during the dark half of the expiry flash |

## Verification
Every key pulse is sampled at one rising edge, and the readout settles right after that edge because the BCD decode is combinational on the state registers. The bench drives and samples on falling edges, so each key result is checked half a cycle after the edge that took the key. After an enter pulse, the bench counts falling edges k from that edge. It expects the value `N - k/CLK_HZ` while k < N·`CLK_HZ`. After that it expects 00, with blank equal to 1 exactly when `(k - N·CLK_HZ) mod CLK_HZ >= CLK_HZ/2`. Stray up, down and enter pulses are injected inside this window, so any disturbance of the one-second schedule shows up at the next step.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic [1:0] {
    MODE_SET  = 2'd0,
    MODE_RUN  = 2'd1,
    MODE_DONE = 2'd2
  } modeT;

  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic loadCount;
    logic decCount;
    logic incInit;
    logic decInit;
  } strobeT;
endpackage

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
  import cdt_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   keySet,
  input  logic   keyUp,
  input  logic   keyDown,
  input  logic   keyEnter,
  input  logic   countIsOne,
  output modeT   mode,
  output strobeT strobes,
  output logic   blankDisp
);
  localparam int PW   = (CLK_HZ > 2) ? $clog2(CLK_HZ) : 1;
  localparam int HALF = CLK_HZ / 2;

  logic [PW-1:0] prescale;
  logic          tick;
  modeT          nextMode;

  assign tick = (prescale == PW'(CLK_HZ - 1));

  always_comb begin
    strobes  = '0;
    nextMode = mode;
    unique case (mode)
      MODE_SET: begin
        if (keyEnter) begin
          strobes.loadCount = 1'b1;
          nextMode          = MODE_RUN;
        end else if (keyUp) begin
          strobes.incInit = 1'b1;
        end else if (keyDown) begin
          strobes.decInit = 1'b1;
        end
      end
      MODE_RUN: begin
        if (keySet) begin
          nextMode = MODE_SET;
        end else if (tick) begin
          strobes.decCount = 1'b1;
          if (countIsOne) nextMode = MODE_DONE;
        end
      end
      MODE_DONE: begin
        if (keySet) nextMode = MODE_SET;
      end
      default: nextMode = MODE_SET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode     <= MODE_SET;
      prescale <= '0;
    end else begin
      mode <= nextMode;
      if (strobes.loadCount || nextMode == MODE_SET || tick) prescale <= '0;
      else                                                   prescale <= prescale + 1'b1;
    end
  end

  assign blankDisp = (mode == MODE_DONE) && (prescale >= PW'(HALF));

  // R8: the readout goes dark only while expired
  p_blank_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    blankDisp |-> mode == MODE_DONE);
  // R7: set leaves counting or expired for setting mode
  p_set_exit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (mode != MODE_SET && keySet) |=> mode == MODE_SET);
  // R4: set alone in setting mode keeps the mode
  p_set_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SET && keySet && !keyEnter) |=> mode == MODE_SET);
  // R5: countdown starts from a cleared prescaler
  p_start_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SET && keyEnter) |=> (mode == MODE_RUN && prescale == '0));
endmodule

// File: rtl/cdt_datapath.sv
module cdt_datapath
  import cdt_pkg::*;
#(
  parameter int MAX_SECS = 59
) (
  input  logic       clk,
  input  logic       rstN,
  input  modeT       mode,
  input  strobeT     strobes,
  output logic       countIsOne,
  output logic [3:0] tensBcd,
  output logic [3:0] onesBcd
);
  localparam int VW = $clog2(MAX_SECS + 1);

  logic [VW-1:0] initVal;
  logic [VW-1:0] count;
  logic [VW-1:0] dispVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initVal <= VW'(1);
    end else if (strobes.incInit) begin
      initVal <= (initVal == VW'(MAX_SECS)) ? VW'(1) : initVal + 1'b1;
    end else if (strobes.decInit) begin
      initVal <= (initVal == VW'(1)) ? VW'(MAX_SECS) : initVal - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 count <= '0;
    else if (strobes.loadCount) count <= initVal;
    else if (strobes.decCount)  count <= count - 1'b1;
  end

  assign countIsOne = (count == VW'(1));
  assign dispVal    = (mode == MODE_SET) ? initVal : count;
  assign tensBcd    = 4'(dispVal / VW'(10));
  assign onesBcd    = 4'(dispVal % VW'(10));

  // R2 R3: start value stays within 1..MAX_SECS
  p_init_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (initVal >= VW'(1)) && (initVal <= VW'(MAX_SECS)));
  // R6: start value frozen outside setting mode
  p_init_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode != MODE_SET) |=> $stable(initVal));
  // R5: each one-second step removes exactly one
  p_dec_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.decCount |=> count == $past(count) - 1'b1);
  // R5: the counter starts at the start value
  p_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCount |=> count == $past(initVal));
endmodule

// File: rtl/countdown_secs.sv
module countdown_secs #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int MAX_SECS = 59
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       keySet,
  input  logic       keyUp,
  input  logic       keyDown,
  input  logic       keyEnter,
  output logic [3:0] tensBcd,
  output logic [3:0] onesBcd,
  output logic       blankDisp
);
  cdt_pkg::modeT   mode;
  cdt_pkg::strobeT strobes;
  logic            countIsOne;

  cdt_ctrl #(.CLK_HZ(CLK_HZ)) u_ctrl (
    .clk(clk), .rstN(rstN), .keySet(keySet), .keyUp(keyUp), .keyDown(keyDown),
    .keyEnter(keyEnter), .countIsOne(countIsOne), .mode(mode), .strobes(strobes),
    .blankDisp(blankDisp)
  );

  cdt_datapath #(.MAX_SECS(MAX_SECS)) u_dp (
    .clk(clk), .rstN(rstN), .mode(mode), .strobes(strobes),
    .countIsOne(countIsOne), .tensBcd(tensBcd), .onesBcd(onesBcd)
  );
endmodule

// File: tb/countdown_secs_tb.sv
module countdown_secs_tb;
  localparam int HZ  = 8;
  localparam int MAXS = 59;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic keySet = 1'b0, keyUp = 1'b0, keyDown = 1'b0, keyEnter = 1'b0;
  logic [3:0] tensBcd, onesBcd;
  logic blankDisp;
  int total = 0;
  int bad = 0;
  int initM = 1;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  countdown_secs #(.CLK_HZ(HZ), .MAX_SECS(MAXS)) u_dut (
    .clk(clk), .rstN(rstN), .keySet(keySet), .keyUp(keyUp), .keyDown(keyDown),
    .keyEnter(keyEnter), .tensBcd(tensBcd), .onesBcd(onesBcd), .blankDisp(blankDisp)
  );

  task automatic check(string req, int expVal, bit expBlank);
    total++;
    if (tensBcd != 4'(expVal / 10) || onesBcd != 4'(expVal % 10) || blankDisp != expBlank) begin
      bad++;
      $display("FAIL %s: got %0d%0d blank=%0b, expected %0d%0d blank=%0b", req,
               tensBcd, onesBcd, blankDisp, expVal / 10, expVal % 10, expBlank);
    end
  endtask

  // drive at a falling edge, taken at the next rising edge, return at the falling edge after
  task automatic pulse(bit s, bit u, bit d, bit e);
    keySet = s; keyUp = u; keyDown = d; keyEnter = e;
    @(negedge clk);
    keySet = 0; keyUp = 0; keyDown = 0; keyEnter = 0;
  endtask

  // after enter: k counts falling edges from the loading edge; stray keys are injected
  task automatic run_check(int n, int extra, string req);
    for (int k = 0; k < n * HZ + extra; k++) begin
      int v;
      bit b;
      v = (k < n * HZ) ? n - k / HZ : 0;
      b = (k >= n * HZ) && (((k - n * HZ) % HZ) >= HZ / 2);
      check(req, v, b);
      keyUp    = (k == 2) || (k == n * HZ + 1);  // R6 stray up
      keyDown  = (k == 3) || (k == n * HZ + 5);  // R6 stray down
      keyEnter = (k == 5) || (k == n * HZ + 6);  // R6 stray enter
      @(negedge clk);
    end
    keyUp = 0; keyDown = 0; keyEnter = 0;
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 reset", 1, 0);

    // R2 sweep with wrap, R9 BCD across the whole range
    for (int i = 0; i < MAXS + 1; i++) begin
      pulse(0, 1, 0, 0);
      initM = (initM == MAXS) ? 1 : initM + 1;
      check("R2 up / R9", initM, 0);
    end
    // R3 sweep with wrap
    for (int i = 0; i < MAXS + 1; i++) begin
      pulse(0, 0, 1, 0);
      initM = (initM == 1) ? MAXS : initM - 1;
      check("R3 down / R9", initM, 0);
    end

    // R4: set ignored in setting; up beats down; enter beats up
    pulse(1, 0, 0, 0);
    check("R4 set ignored", initM, 0);
    pulse(0, 1, 0, 0);
    initM = (initM == MAXS) ? 1 : initM + 1;
    check("R4 still setting", initM, 0);
    pulse(0, 1, 1, 0);
    initM = (initM == MAXS) ? 1 : initM + 1;
    check("R4 up over down", initM, 0);
    while (initM != 3) begin
      pulse(0, 0, 1, 0);
      initM = (initM == 1) ? MAXS : initM - 1;
    end
    check("R3 set to 3", 3, 0);

    // R5 R6 R8: enter together with up; enter wins, countdown from 3
    pulse(0, 1, 0, 1);
    run_check(3, 3 * HZ, "R5 R6 R8 countdown 3");
    // R7 from expired
    pulse(1, 0, 0, 0);
    check("R7 set from expired", 3, 0);

    // R7 from counting, mid-second
    pulse(0, 0, 0, 1);
    repeat (HZ + 3) @(negedge clk);
    check("R5 after one step", 2, 0);
    pulse(1, 0, 0, 0);
    check("R7 set from counting", 3, 0);
    // restart after a stop: prescaler cleared again
    pulse(0, 0, 0, 1);
    run_check(3, HZ, "R5 restart");
    pulse(1, 0, 0, 0);

    // R9 long countdown from 59 covers every BCD value
    while (initM != MAXS) begin
      pulse(0, 1, 0, 0);
      initM = (initM == MAXS) ? 1 : initM + 1;
    end
    pulse(0, 0, 0, 1);
    run_check(MAXS, 2 * HZ, "R9 R8 countdown 59");
    pulse(1, 0, 0, 0);
    check("R7 back to setting", MAXS, 0);

    // start value 1
    pulse(0, 1, 0, 0);
    initM = 1;
    check("R2 wrap to 1", 1, 0);
    pulse(0, 0, 0, 1);
    run_check(1, 2 * HZ, "R5 R8 countdown 1");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule